// File: doc/BRIEF.md
# Zero-Overhead Loop Repeat Controller

This block gives a processor with 16-bit instructions hardware loops that cost no branch instructions. It keeps a loop start address, a loop end address and a 32-bit status word. The status word carries a 12-bit iteration counter and a 2-bit loop-length code. Commands from the decoder load the addresses, load the counter in one of two forms, or overwrite the whole status word. The block watches every fetch address. When fetch reaches the loop end with more than one iteration left, it raises a redirect toward the loop start in the same cycle and counts down by one.

A small state machine tracks how many iterations remain. `RPT_IDLE` means the counter is zero. `RPT_LAST` means one pass remains. `RPT_LOOP` means two or more remain. A count load or status write enters whichever state matches the new count: zero goes to `RPT_IDLE`, one to `RPT_LAST`, and more than one to `RPT_LOOP`. A fetch at the end address moves `RPT_LOOP` to `RPT_LOOP` while the count is above 2, and to `RPT_LAST` when the count was exactly 2. The same fetch moves `RPT_LAST` to `RPT_IDLE`. In `RPT_IDLE` the same fetch changes nothing. Only `RPT_LOOP` issues redirects.

Top module: `loop_repeat_ctrl`

## Requirements
- R1: A synchronous reset clears the start address, the end address and the whole status word to zero, and `redirect` stays low after reset.
- R2: When `cmd_valid` is high, `cmd_op` selects the command. Op 1 loads the start address and op 2 loads the end address, both from `cmd_data`. Op 3 and op 4, the generic control path, load the start and end address in the same way.
- R3: Op 6, the immediate count load, writes `cmd_data[7:0]` into status bits 23:16 and clears status bits 27:24. `cmd_data[31:8]` has no effect.
- R4: Op 7, the register count load, copies `cmd_data[11:0]` into status bits 27:16. `cmd_data[31:12]` has no effect.
- R5: Both count loads also write a loop-length code into status bits 3:2. The code comes from the start and end addresses held at that moment. The body length is ((end − start) >> 1) + 1. A length of 1 gives 00, 2 gives 01, 3 gives 11, and 4 or more gives 10.
- R6: `range_err` is high whenever end < start. A count load made while `range_err` is high writes code 00.
- R7: When `fetch_valid` is high, `fetch_addr` equals the end address and the count is above 1, `redirect` is high in that same cycle with `redirect_addr` equal to the start address. The count drops by one at the next edge.
- R8: A fetch at the end address when the count is 1 leaves `redirect` low and clears the count to 0. When the count is 0, such a fetch leaves `redirect` low and the count stays 0.
- R9: Op 5 writes all 32 status bits, counter and code included. The two count loads leave every status bit outside 27:16 and 3:2 unchanged.
- R10: A command and a fetch at the end address in the same cycle: `redirect` follows the count held before the edge, and the command alone decides the next count.
- R11: A fetch with `fetch_valid` low, or at any address other than the end address, changes neither `redirect` nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R2 to R4, R9) |
| cmd_data | input | 32 | Command operand |
| fetch_valid | input | 1 | Fetch address is valid |
| fetch_addr | input | AW | Current fetch address |
| redirect | output | 1 | Jump fetch to the loop start this cycle |
| redirect_addr | output | AW | Loop start address |
| status_word | output | 32 | Status word with counter and length code |
| start_addr | output | AW | Loop start register |
| end_addr | output | AW | Loop end register |
| range_err | output | 1 | End address is below start address |

## Verification
The bench builds the block with a 16-bit address width (AW = 16). This keeps every address a short literal and still reaches the end < start error and all four length codes. The counter field keeps its full 12 bits. The bench can therefore load 0xFFF and show that the immediate form clears the top nibble. It runs a three-iteration loop down to fall-through, which covers every state and transition of the iteration state machine.

// File: rtl/loop_repeat_pkg.sv
package loop_repeat_pkg;

    typedef enum logic [2:0] {
        CMD_NONE       = 3'd0,
        CMD_LD_START   = 3'd1,
        CMD_LD_END     = 3'd2,
        CMD_CTL_START  = 3'd3,
        CMD_CTL_END    = 3'd4,
        CMD_CTL_STATUS = 3'd5,
        CMD_CNT_IMM    = 3'd6,
        CMD_CNT_REG    = 3'd7
    } rpt_cmd_e;

    typedef enum logic [1:0] {
        RPT_IDLE = 2'd0,
        RPT_LAST = 2'd1,
        RPT_LOOP = 2'd2
    } rpt_state_e;

    localparam int SW_W    = 32;
    localparam int CNT_LSB = 16;
    localparam int CNT_W   = 12;
    localparam int CNT_MSB = CNT_LSB + CNT_W - 1;
    localparam int IMM_W   = 8;
    localparam int FLG_LSB = 2;
    localparam int FLG_MSB = FLG_LSB + 1;

    localparam logic [1:0] LEN_ONE   = 2'b00;
    localparam logic [1:0] LEN_TWO   = 2'b01;
    localparam logic [1:0] LEN_THREE = 2'b11;
    localparam logic [1:0] LEN_MANY  = 2'b10;

endpackage

// File: rtl/loop_addr_regs.sv
module loop_addr_regs #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_start,
    input  logic          wr_end,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] start_q,
    output logic [AW-1:0] end_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            end_q   <= '0;
        end else begin
            if (wr_start) start_q <= wdata;
            if (wr_end)   end_q   <= wdata;
        end
    end

endmodule

// File: rtl/loop_len_flags.sv
module loop_len_flags
    import loop_repeat_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] end_addr,
    output logic [1:0]    len_code,
    output logic          bad_range
);

    logic [AW-1:0] span;
    logic [AW-1:0] steps;

    always_comb begin
        bad_range = (end_addr < start_addr);
        span      = end_addr - start_addr;
        steps     = span >> 1;
        if (bad_range) begin
            len_code = LEN_ONE;
        end else if (steps == '0) begin
            len_code = LEN_ONE;
        end else if (steps == AW'(1)) begin
            len_code = LEN_TWO;
        end else if (steps == AW'(2)) begin
            len_code = LEN_THREE;
        end else begin
            len_code = LEN_MANY;
        end
    end

endmodule

// File: rtl/loop_repeat_ctrl.sv
module loop_repeat_ctrl
    import loop_repeat_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [31:0]   cmd_data,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    output logic          redirect,
    output logic [AW-1:0] redirect_addr,
    output logic [31:0]   status_word,
    output logic [AW-1:0] start_addr,
    output logic [AW-1:0] end_addr,
    output logic          range_err
);

    localparam int WIDE_AW = (AW > SW_W) ? 1 : 0;

    rpt_cmd_e        op;
    rpt_state_e      st_q, st_d;
    logic [SW_W-1:0] sr_q, sr_d;
    logic [CNT_W-1:0] cnt_q, cnt_new;
    logic [1:0]      len_code;
    logic            wr_start, wr_end, end_hit;
    logic [AW-1:0]   addr_wdata;

    assign op = rpt_cmd_e'(cmd_op);

    generate
        if (WIDE_AW != 0) begin : g_wide
            assign addr_wdata = AW'(cmd_data);
        end else begin : g_narrow
            assign addr_wdata = cmd_data[AW-1:0];
        end
    endgenerate

    assign wr_start = cmd_valid && (op == CMD_LD_START || op == CMD_CTL_START);
    assign wr_end   = cmd_valid && (op == CMD_LD_END   || op == CMD_CTL_END);

    loop_addr_regs #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .wr_start (wr_start),
        .wr_end   (wr_end),
        .wdata    (addr_wdata),
        .start_q  (start_addr),
        .end_q    (end_addr)
    );

    loop_len_flags #(.AW(AW)) u_len (
        .start_addr (start_addr),
        .end_addr   (end_addr),
        .len_code   (len_code),
        .bad_range  (range_err)
    );

    function automatic rpt_state_e state_for(input logic [CNT_W-1:0] c);
        if (c == '0)            return RPT_IDLE;
        else if (c == CNT_W'(1)) return RPT_LAST;
        else                     return RPT_LOOP;
    endfunction

    assign cnt_q   = sr_q[CNT_MSB:CNT_LSB];
    assign end_hit = fetch_valid && (fetch_addr == end_addr);

    // next-state and status-word update
    always_comb begin
        sr_d    = sr_q;
        st_d    = st_q;
        cnt_new = '0;
        if (cmd_valid && op == CMD_CNT_IMM) begin
            cnt_new                  = CNT_W'(cmd_data[IMM_W-1:0]);
            sr_d[CNT_MSB:CNT_LSB]    = cnt_new;
            sr_d[FLG_MSB:FLG_LSB]    = len_code;
            st_d                     = state_for(cnt_new);
        end else if (cmd_valid && op == CMD_CNT_REG) begin
            cnt_new                  = cmd_data[CNT_W-1:0];
            sr_d[CNT_MSB:CNT_LSB]    = cnt_new;
            sr_d[FLG_MSB:FLG_LSB]    = len_code;
            st_d                     = state_for(cnt_new);
        end else if (cmd_valid && op == CMD_CTL_STATUS) begin
            sr_d = cmd_data;
            st_d = state_for(cmd_data[CNT_MSB:CNT_LSB]);
        end else if (end_hit) begin
            unique case (st_q)
                RPT_LOOP: begin
                    sr_d[CNT_MSB:CNT_LSB] = cnt_q - CNT_W'(1);
                    st_d = (cnt_q == CNT_W'(2)) ? RPT_LAST : RPT_LOOP;
                end
                RPT_LAST: begin
                    sr_d[CNT_MSB:CNT_LSB] = '0;
                    st_d = RPT_IDLE;
                end
                RPT_IDLE: begin
                    st_d = RPT_IDLE;
                end
                default: begin
                    st_d = RPT_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= RPT_IDLE;
            sr_q <= '0;
        end else begin
            st_q <= st_d;
            sr_q <= sr_d;
        end
    end

    // outputs
    always_comb begin
        redirect      = end_hit && (st_q == RPT_LOOP);
        redirect_addr = start_addr;
        status_word   = sr_q;
    end

    // R7
    redirect_needs_count_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (status_word[CNT_MSB:CNT_LSB] > CNT_W'(1)));

    // R7
    loop_decrement_chk: assert property (@(posedge clk) disable iff (rst)
        (end_hit && !cmd_valid && cnt_q > CNT_W'(1))
        |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R8
    fall_through_chk: assert property (@(posedge clk) disable iff (rst)
        (end_hit && !cmd_valid && cnt_q <= CNT_W'(1)) |=> (cnt_q == '0) && !redirect);

    // R3
    imm_top_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == CMD_CNT_IMM) |=> (status_word[CNT_MSB:CNT_MSB-3] == 4'h0));

    // R1
    idle_means_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == RPT_IDLE) |-> (cnt_q == '0));

    // R9
    passthrough_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (op == CMD_CNT_IMM || op == CMD_CNT_REG))
        |=> (status_word[SW_W-1:CNT_MSB+1] == $past(sr_q[SW_W-1:CNT_MSB+1])) &&
            (status_word[CNT_LSB-1:FLG_MSB+1] == $past(sr_q[CNT_LSB-1:FLG_MSB+1])) &&
            (status_word[FLG_LSB-1:0] == $past(sr_q[FLG_LSB-1:0])));

endmodule

// File: tb/loop_repeat_ctrl_tb.sv
module loop_repeat_ctrl_tb;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          cmd_valid;
    logic [2:0]    cmd_op;
    logic [31:0]   cmd_data;
    logic          fetch_valid;
    logic [AW-1:0] fetch_addr;
    logic          redirect;
    logic [AW-1:0] redirect_addr;
    logic [31:0]   status_word;
    logic [AW-1:0] start_addr;
    logic [AW-1:0] end_addr;
    logic          range_err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    loop_repeat_ctrl #(.AW(AW)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .redirect(redirect), .redirect_addr(redirect_addr),
        .status_word(status_word), .start_addr(start_addr),
        .end_addr(end_addr), .range_err(range_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_code(input int s, input int e);
        int len;
        if (e < s) return 2'b00;
        len = ((e - s) >> 1) + 1;
        if (len == 1) return 2'b00;
        if (len == 2) return 2'b01;
        if (len == 3) return 2'b11;
        return 2'b10;
    endfunction

    // drive at posedge+2, commit at next edge, leave at posedge+2
    task automatic cmd(input logic [2:0] op, input logic [31:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        @(posedge clk); #2;
        cmd_valid = 1'b0; cmd_op = 3'd0; cmd_data = '0;
    endtask

    task automatic fetch_at(input logic [AW-1:0] a, input logic exp_redir, input string req);
        fetch_valid = 1'b1; fetch_addr = a;
        #1;
        check(req, {31'd0, redirect}, {31'd0, exp_redir});
        if (exp_redir) check(req, {16'd0, redirect_addr}, {16'd0, start_addr});
        @(posedge clk); #2;
        fetch_valid = 1'b0;
    endtask

    function automatic logic [11:0] cnt();
        return status_word[27:16];
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        @(posedge clk); @(posedge clk); #2;
        rst = 1'b0;
        check("R1 status", status_word, 32'h0);
        check("R1 start", {16'd0, start_addr}, 32'h0);
        check("R1 end", {16'd0, end_addr}, 32'h0);
        fetch_valid = 1'b1; fetch_addr = '0; #1;
        check("R1 redirect", {31'd0, redirect}, 32'h0);
        fetch_valid = 1'b0;
        @(posedge clk); #2;
    endtask

    task automatic t_addr_loads();
        cmd(3'd1, 32'h0000_0100);
        cmd(3'd2, 32'h0000_0106);
        check("R2 dedicated start", {16'd0, start_addr}, 32'h100);
        check("R2 dedicated end", {16'd0, end_addr}, 32'h106);
        cmd(3'd3, 32'h0000_0300);
        cmd(3'd4, 32'h0000_0310);
        check("R2 generic start", {16'd0, start_addr}, 32'h300);
        check("R2 generic end", {16'd0, end_addr}, 32'h310);
    endtask

    task automatic t_count_forms();
        cmd(3'd7, 32'hFFFF_FFFF);
        check("R4 reg form all ones", {20'd0, cnt()}, 32'hFFF);
        cmd(3'd6, 32'hFFFF_F1AB);
        check("R3 imm form", {20'd0, cnt()}, 32'h0AB);
        cmd(3'd7, 32'h1234_5ABC);
        check("R4 reg form", {20'd0, cnt()}, 32'hABC);
    endtask

    task automatic t_codes();
        int ends[5] = '{'h200, 'h202, 'h204, 'h206, 'h220};
        cmd(3'd1, 32'h200);
        foreach (ends[i]) begin
            cmd(3'd2, ends[i]);
            cmd(3'd6, 32'h5);
            check("R5 length code", {30'd0, status_word[3:2]}, {30'd0, exp_code('h200, ends[i])});
        end
        cmd(3'd2, 32'h1FE);
        #1;
        check("R6 range_err", {31'd0, range_err}, 32'h1);
        cmd(3'd6, 32'h5);
        check("R6 code on error", {30'd0, status_word[3:2]}, 32'h0);
        cmd(3'd2, 32'h200);
        #1;
        check("R6 range_err clear", {31'd0, range_err}, 32'h0);
    endtask

    task automatic t_loop();
        cmd(3'd1, 32'h100);
        cmd(3'd2, 32'h106);
        cmd(3'd6, 32'h3);
        fetch_at(16'h104, 1'b0, "R11 other addr");
        check("R11 count kept", {20'd0, cnt()}, 32'h3);
        fetch_addr = 16'h106; fetch_valid = 1'b0; #1;
        check("R11 invalid fetch", {31'd0, redirect}, 32'h0);
        @(posedge clk); #2;
        check("R11 count kept invalid", {20'd0, cnt()}, 32'h3);
        fetch_at(16'h106, 1'b1, "R7 first redirect");
        check("R7 decrement", {20'd0, cnt()}, 32'h2);
        fetch_at(16'h106, 1'b1, "R7 second redirect");
        check("R7 decrement to 1", {20'd0, cnt()}, 32'h1);
        fetch_at(16'h106, 1'b0, "R8 fall through");
        check("R8 count zero", {20'd0, cnt()}, 32'h0);
        fetch_at(16'h106, 1'b0, "R8 idle no redirect");
        check("R8 stays zero", {20'd0, cnt()}, 32'h0);
    endtask

    task automatic t_status();
        logic [31:0] e;
        cmd(3'd5, 32'hA5A5_A5A5);
        check("R9 full write", status_word, 32'hA5A5_A5A5);
        cmd(3'd1, 32'h400);
        cmd(3'd2, 32'h400);
        cmd(3'd6, 32'h12);
        e = 32'hA5A5_A5A5;
        e[27:16] = 12'h012;
        e[3:2] = 2'b00;
        check("R9 passthrough", status_word, e);
    endtask

    task automatic t_collision();
        cmd(3'd1, 32'h500);
        cmd(3'd2, 32'h508);
        cmd(3'd6, 32'h3);
        cmd_valid = 1'b1; cmd_op = 3'd6; cmd_data = 32'h9;
        fetch_valid = 1'b1; fetch_addr = 16'h508;
        #1;
        check("R10 redirect from old count", {31'd0, redirect}, 32'h1);
        @(posedge clk); #2;
        cmd_valid = 1'b0; fetch_valid = 1'b0;
        check("R10 command wins", {20'd0, cnt()}, 32'h9);
    endtask

    initial begin
        cmd_valid = 0; cmd_op = 0; cmd_data = 0;
        fetch_valid = 0; fetch_addr = 0; rst = 1;
        @(posedge clk); #2;
        t_reset();
        t_addr_loads();
        t_count_forms();
        t_codes();
        t_loop();
        t_status();
        t_collision();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule